// File: doc/BRIEF.md
# Programmable LUT Cell Mesh

The block is a rectangular array of identical one-bit cells. Each cell exchanges exactly one bit with each of its four orthogonal neighbours. Every cell is a router and a logic element at once. Each of its four outputs is looked up in its own 16-entry truth table, and the table is addressed by the cell's four input bits. No wire in the fabric is longer than one cell pitch and no wire is shared. A computation is laid out across the array purely as truth-table contents.

Edge cells that have no neighbour on a side take that input from a boundary port and drive that output to a matching boundary port. Each cell output is a flip-flop on the common clock, so a bit advances one cell per cycle. The truth tables sit in a single serial shift chain that is filled while the configuration enable is high. After reset, every cell holds a pass-through program, which turns the mesh into straight wires running in both axes.

Top module: `lutMesh`

## Requirements
- R1: After reset every boundary output is 0, and every cell holds the pass-through program.
- R2: A cell's table index is {W,S,E,N}, with the north input as bit 0. Output d (N=0, E=1, S=2, W=3) takes configuration bit d*16+index of that cell's 64 bits.
- R3: Every cell output is registered. A bit driven on westIn[r] and held across one clock edge appears on eastOut[r] COLS edges later, and a bit on northIn[c] appears on southOut[c] ROWS edges later.
- R4: Cells connect only to their adjacent cells. An interior input is the facing output of the neighbour on that side, registered one cycle earlier.
- R5: The pass-through program routes west to east, east to west, north to south and south to north at the same time and independently.
- R6: While cfgEn is high, one cfgIn bit enters per clock edge. Bit j of the cell at row r, column c is the ((r*COLS+c)*64+j)-th bit shifted in, counting from 0, once ROWS*COLS*64 bits have been shifted.
- R7: At every clock edge where cfgEn is high, all cell outputs, and so all boundary outputs, are registered as 0.
- R8: While cfgEn is low, the configuration does not change, whatever cfgIn does.
- R9: northIn[c], southIn[c], northOut[c] and southOut[c] belong to column c. westIn[r], eastIn[r], westOut[r] and eastOut[r] belong to row r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgEn | input | 1 | Configuration shift enable |
| cfgIn | input | 1 | Serial configuration data |
| northIn | input | COLS | Inputs into the top row |
| southIn | input | COLS | Inputs into the bottom row |
| westIn | input | ROWS | Inputs into the left column |
| eastIn | input | ROWS | Inputs into the right column |
| northOut | output | COLS | Top row north outputs |
| southOut | output | COLS | Bottom row south outputs |
| westOut | output | ROWS | Left column west outputs |
| eastOut | output | ROWS | Right column east outputs |

## Verification
The bench builds the mesh with ROWS=2 and COLS=3. Because the array is not square, a swap of rows and columns in the wiring, in the bus mapping or in the chain order changes the observed outputs. The two axes also have different latencies, so a wrong crossing time on either axis shows up separately. The chain is only 384 bits long, so a full random program, a structured parity program and the reset back to pass-through all fit in a short run.

// File: rtl/meshPkg.sv
package meshPkg;
  localparam int LUT_ENTRIES = 16;
  localparam int CELL_DIRS   = 4;
  localparam int CELL_BITS   = LUT_ENTRIES * CELL_DIRS;

  // Per-direction tables, direction order N=0, E=1, S=2, W=3; index {W,S,E,N}
  localparam logic [LUT_ENTRIES-1:0] PASS_N = 16'hF0F0; // copies S input
  localparam logic [LUT_ENTRIES-1:0] PASS_E = 16'hFF00; // copies W input
  localparam logic [LUT_ENTRIES-1:0] PASS_S = 16'hAAAA; // copies N input
  localparam logic [LUT_ENTRIES-1:0] PASS_W = 16'hCCCC; // copies E input
  localparam logic [CELL_BITS-1:0]   PASS_TABLE = {PASS_W, PASS_S, PASS_E, PASS_N};

  typedef struct packed {
    logic shift;
    logic clear;
  } meshStrobes_t;
endpackage

// File: rtl/meshCtrl.sv
module meshCtrl
  import meshPkg::*;
(
  input  logic         cfgEn,
  output meshStrobes_t strobes
);
  always_comb begin
    strobes.shift = cfgEn;
    strobes.clear = cfgEn;
  end
endmodule

// File: rtl/meshCell.sv
module meshCell
  import meshPkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic [CELL_BITS-1:0] tbl,
  input  logic                 inN,
  input  logic                 inE,
  input  logic                 inS,
  input  logic                 inW,
  output logic                 outN,
  output logic                 outE,
  output logic                 outS,
  output logic                 outW
);
  logic [3:0] lutIdx;
  logic [CELL_DIRS-1:0] nextOut;

  assign lutIdx = {inW, inS, inE, inN};

  always_comb begin
    for (int d = 0; d < CELL_DIRS; d++) begin
      nextOut[d] = tbl[{2'(d), lutIdx}];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      {outW, outS, outE, outN} <= '0;
    end else begin
      {outW, outS, outE, outN} <= nextOut;
    end
  end

  // R7: clear forces every output low on the following cycle
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
    clear |=> ({outW, outS, outE, outN} == 4'b0000));

  // R5: a pass-through cell behaves as four straight wires with one register
  p_pass_wires_r5: assert property (@(posedge clk) disable iff (rst)
    (!clear && tbl == PASS_TABLE) |=>
      (outE == $past(inW) && outW == $past(inE) &&
       outS == $past(inN) && outN == $past(inS)));
endmodule

// File: rtl/meshDatapath.sv
module meshDatapath
  import meshPkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  meshStrobes_t    strobes,
  input  logic            cfgIn,
  input  logic [COLS-1:0] northIn,
  input  logic [COLS-1:0] southIn,
  input  logic [ROWS-1:0] westIn,
  input  logic [ROWS-1:0] eastIn,
  output logic [COLS-1:0] northOut,
  output logic [COLS-1:0] southOut,
  output logic [ROWS-1:0] westOut,
  output logic [ROWS-1:0] eastOut
);
  localparam int NCELLS = ROWS * COLS;
  localparam int CHAIN  = NCELLS * CELL_BITS;

  logic [CHAIN-1:0]  cfgChain;
  logic [NCELLS-1:0] cellN, cellE, cellS, cellW;

  // Serial chain: new bits enter at the top and move toward cell 0, bit 0
  always_ff @(posedge clk) begin
    if (rst) begin
      cfgChain <= {NCELLS{PASS_TABLE}};
    end else if (strobes.shift) begin
      cfgChain <= {cfgIn, cfgChain[CHAIN-1:1]};
    end
  end

  p_cfg_shift_r6: assert property (@(posedge clk) disable iff (rst)
    strobes.shift |=> (cfgChain[CHAIN-1] == $past(cfgIn) &&
                       cfgChain[CHAIN-2:0] == $past(cfgChain[CHAIN-1:1])));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !strobes.shift |=> $stable(cfgChain));

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int K = r * COLS + c;
      logic srcN, srcE, srcS, srcW;

      if (r == 0) begin : g_top
        assign srcN = northIn[c];
      end else begin : g_topInner
        assign srcN = cellS[K-COLS];
      end
      if (r == ROWS-1) begin : g_bot
        assign srcS = southIn[c];
      end else begin : g_botInner
        assign srcS = cellN[K+COLS];
      end
      if (c == 0) begin : g_left
        assign srcW = westIn[r];
      end else begin : g_leftInner
        assign srcW = cellE[K-1];
      end
      if (c == COLS-1) begin : g_right
        assign srcE = eastIn[r];
      end else begin : g_rightInner
        assign srcE = cellW[K+1];
      end

      meshCell u_cell (
        .clk  (clk),
        .rst  (rst),
        .clear(strobes.clear),
        .tbl  (cfgChain[K*CELL_BITS +: CELL_BITS]),
        .inN  (srcN),
        .inE  (srcE),
        .inS  (srcS),
        .inW  (srcW),
        .outN (cellN[K]),
        .outE (cellE[K]),
        .outS (cellS[K]),
        .outW (cellW[K])
      );
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_colEdge
    assign northOut[c] = cellN[c];
    assign southOut[c] = cellS[(ROWS-1)*COLS + c];
  end
  for (genvar r = 0; r < ROWS; r++) begin : g_rowEdge
    assign westOut[r] = cellW[r*COLS];
    assign eastOut[r] = cellE[r*COLS + COLS-1];
  end
endmodule

// File: rtl/lutMesh.sv
module lutMesh
  import meshPkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfgEn,
  input  logic            cfgIn,
  input  logic [COLS-1:0] northIn,
  input  logic [COLS-1:0] southIn,
  input  logic [ROWS-1:0] westIn,
  input  logic [ROWS-1:0] eastIn,
  output logic [COLS-1:0] northOut,
  output logic [COLS-1:0] southOut,
  output logic [ROWS-1:0] westOut,
  output logic [ROWS-1:0] eastOut
);
  meshStrobes_t strobes;

  meshCtrl u_ctrl (
    .cfgEn  (cfgEn),
    .strobes(strobes)
  );

  meshDatapath #(.ROWS(ROWS), .COLS(COLS)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .cfgIn   (cfgIn),
    .northIn (northIn),
    .southIn (southIn),
    .westIn  (westIn),
    .eastIn  (eastIn),
    .northOut(northOut),
    .southOut(southOut),
    .westOut (westOut),
    .eastOut (eastOut)
  );

  // R7: boundary outputs read zero one cycle after a configuration edge
  p_edge_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    cfgEn |=> (northOut == '0 && southOut == '0 && westOut == '0 && eastOut == '0));
endmodule

// File: tb/lutMesh_test.sv
`timescale 1ns/1ps
module lutMesh_test;
  localparam int R   = 2;
  localparam int C   = 3;
  localparam int NC  = R * C;
  localparam int TOT = NC * 64;
  localparam int OW  = 2 * C + 2 * R;

  logic clk = 1'b0, rst = 1'b1, cfgEn = 1'b0, cfgIn = 1'b0;
  logic [C-1:0] nIn = '0, sIn = '0, nOut, sOut;
  logic [R-1:0] wIn = '0, eIn = '0, wOut, eOut;

  always #2.5 clk = ~clk;

  lutMesh #(.ROWS(R), .COLS(C)) uut (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgIn(cfgIn),
    .northIn(nIn), .southIn(sIn), .westIn(wIn), .eastIn(eIn),
    .northOut(nOut), .southOut(sOut), .westOut(wOut), .eastOut(eOut)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int           due;
    logic [OW-1:0] exp;
    string        tag;
  } item_t;
  item_t sb[$];

  // Reference model, built from the requirements
  logic mN[NC], mE[NC], mS[NC], mW[NC];
  logic [TOT-1:0] mCfg;
  localparam logic [63:0] PASS = {16'hCCCC, 16'hAAAA, 16'hFF00, 16'hF0F0};

  function automatic logic [OW-1:0] modelOuts();
    logic [C-1:0] n, s;
    logic [R-1:0] w, e;
    for (int c = 0; c < C; c++) begin
      n[c] = mN[c];
      s[c] = mS[(R-1)*C + c];
    end
    for (int r = 0; r < R; r++) begin
      w[r] = mW[r*C];
      e[r] = mE[r*C + C-1];
    end
    return {n, s, w, e};
  endfunction

  task automatic modelReset();
    for (int k = 0; k < NC; k++) begin
      mN[k] = 0; mE[k] = 0; mS[k] = 0; mW[k] = 0;
    end
    mCfg = {NC{PASS}};
  endtask

  task automatic step(input logic en, input logic bitIn,
                      input logic [C-1:0] n, input logic [C-1:0] s,
                      input logic [R-1:0] w, input logic [R-1:0] e,
                      input string tag);
    logic xN[NC], xE[NC], xS[NC], xW[NC];
    item_t it;
    @(negedge clk);
    cfgEn = en; cfgIn = bitIn; nIn = n; sIn = s; wIn = w; eIn = e;
    for (int k = 0; k < NC; k++) begin
      int r, c, b;
      logic iN, iE, iS, iW;
      logic [3:0] idx;
      r = k / C; c = k % C; b = k * 64;
      iN = (r == 0)   ? n[c] : mS[k-C];
      iS = (r == R-1) ? s[c] : mN[k+C];
      iW = (c == 0)   ? w[r] : mE[k-1];
      iE = (c == C-1) ? e[r] : mW[k+1];
      idx = {iW, iS, iE, iN};
      xN[k] = en ? 1'b0 : mCfg[b + 0  + int'(idx)];
      xE[k] = en ? 1'b0 : mCfg[b + 16 + int'(idx)];
      xS[k] = en ? 1'b0 : mCfg[b + 32 + int'(idx)];
      xW[k] = en ? 1'b0 : mCfg[b + 48 + int'(idx)];
    end
    for (int k = 0; k < NC; k++) begin
      mN[k] = xN[k]; mE[k] = xE[k]; mS[k] = xS[k]; mW[k] = xW[k];
    end
    if (en) mCfg = {bitIn, mCfg[TOT-1:1]};
    it.due = cyc + 1;
    it.exp = modelOuts();
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares design outputs with queued expectations
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if ({nOut, sOut, wOut, eOut} !== it.exp) begin
        errors++;
        $display("FAIL %s cycle %0d: actual %b expected %b",
                 it.tag, cyc, {nOut, sOut, wOut, eOut}, it.exp);
      end
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; cfgEn = 0; cfgIn = 0; nIn = '0; sIn = '0; wIn = '0; eIn = '0;
    repeat (3) @(negedge clk);
    sb.delete();
    modelReset();
    // R1: boundary outputs are zero while and right after reset
    checks++;
    if ({nOut, sOut, wOut, eOut} !== '0) begin
      errors++;
      $display("FAIL R1 reset state: actual %b expected %b", {nOut, sOut, wOut, eOut}, {OW{1'b0}});
    end
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual running expected done");
      summary();
    end
  end

  initial begin
    logic [TOT-1:0] newCfg;
    doReset();

    // R3 R5: west pulse on row 0 and north pulse on column 1 in the same run
    step(0, 0, 3'b010, 3'b000, 2'b01, 2'b00, "R3 R5 pulse");
    for (int i = 0; i < 6; i++) step(0, 0, '0, '0, '0, '0, "R3 R5 crossing");
    // R3 R9: row 1 west pulse, east/south reverse directions
    step(0, 0, '0, 3'b100, 2'b10, 2'b01, "R3 R9 reverse pulse");
    for (int i = 0; i < 6; i++) step(0, 0, '0, '0, '0, '0, "R3 R5 reverse crossing");
    // R4 R5 R9: random patterns through the wire program
    for (int i = 0; i < 16; i++)
      step(0, 1'($urandom), C'($urandom), C'($urandom), R'($urandom), R'($urandom),
           "R4 R5 R9 pass patterns");

    // R6 R7: load a random program while inputs toggle
    for (int i = 0; i < TOT; i++) newCfg[i] = 1'($urandom);
    for (int i = 0; i < TOT; i++)
      step(1, newCfg[i], C'($urandom), C'($urandom), R'($urandom), R'($urandom),
           "R6 R7 random load");
    // R2 R4 R8: run the random program, cfgIn noise must not alter it
    for (int i = 0; i < 40; i++)
      step(0, 1'($urandom), C'($urandom), C'($urandom), R'($urandom), R'($urandom),
           "R2 R4 R8 random program");

    // R2 R6: structured parity program in every table
    for (int i = 0; i < TOT; i++)
      step(1, (i % 16 == 1 || i % 16 == 2 || i % 16 == 4 || i % 16 == 7 ||
               i % 16 == 8 || i % 16 == 11 || i % 16 == 13 || i % 16 == 14),
           '0, '0, '0, '0, "R6 R7 parity load");
    for (int i = 0; i < 30; i++)
      step(0, 1'($urandom), C'($urandom), C'($urandom), R'($urandom), R'($urandom),
           "R2 R8 parity program");

    // R1: reset restores pass-through
    doReset();
    for (int i = 0; i < 12; i++)
      step(0, 1'($urandom), C'($urandom), C'($urandom), R'($urandom), R'($urandom),
           "R1 R5 restored pass");
    for (int i = 0; i < 3; i++) step(0, 0, '0, '0, '0, '0, "R1 drain");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    summary();
  end
endmodule